// File: doc/BRIEF.md
# Row-Latch and Serial Column Interface for a Multiplexed LED Matrix

This block sits between a microprocessor output port and a row-multiplexed LED matrix. The host shares one 8-bit data bus between two strobes. The row strobe stores a control byte. That byte holds a 3-bit row code and an active-low driver enable. The latched code drives a 7-line, active-high row bus.

The column strobe presents a byte to the block. The block picks one bit of that byte, indexed by the latched row code, so a single byte carries one column position for every row of the matrix. Bit 7 of the column byte is a per-column flash override. When it is clear, the picked bit is blanked while the `flash_phase` input is low. The result leaves on `ser_data` with exactly one `ser_clk` pulse, ready for an external chain of shift registers.

Both strobes are asynchronous to the block clock. They pass through synchronisers, and only their rising edges count. A four-state shifter produces the serial clock pulse:

- `SH_IDLE` goes to `SH_SETUP` on a column event. This transition loads the output bit.
- `SH_SETUP` goes to `SH_HIGH`.
- `SH_HIGH` goes to `SH_HOLD`. `ser_clk` is high only while the shifter is in `SH_HIGH`.
- `SH_HOLD` goes back to `SH_IDLE`.

Top module: `row_serial_if`

## Requirements
- R1: After reset, every `row_drive` line is low and both `ser_clk` and `ser_data` are low.
- R2: On a row strobe, bus bits [2:0] are stored as the row code and bus bit 3 as the enable, where 0 means enabled. Bits [7:4] are ignored. With the enable active, a code k from 0 to 6 drives `row_drive[k]` high and all other lines low.
- R3: When the stored bit 3 is 1, all `row_drive` lines are low whatever the code.
- R4: Row code 7 with the enable active drives no `row_drive` line.
- R5: Each column strobe rising edge yields exactly one `ser_clk` pulse, one clock cycle wide.
- R6: The serial bit is column-byte bit [code], using the stored row code. This holds whether the enable is active or not. Code 7 picks bit 7.
- R7: With column-byte bit 7 at 0, the serial bit is forced to 0 when `flash_phase` is low. It is the picked bit when `flash_phase` is high.
- R8: With column-byte bit 7 at 1, `flash_phase` has no effect on the serial bit.
- R9: `ser_data` holds its value for one full clock cycle before the rising edge of `ser_clk`, and for one full cycle after its falling edge.
- R10: A column strobe leaves `row_drive` unchanged. A row strobe produces no `ser_clk` pulse.
- R11: `flash_phase` is sampled at the column event. A later change does not alter the bit being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 8 | Shared host data bus, held stable while either strobe is high |
| row_stb | input | 1 | Row-control strobe (asynchronous, rising edge active) |
| col_stb | input | 1 | Column-data strobe (asynchronous, rising edge active) |
| flash_phase | input | 1 | Flash oscillator phase, 1 = visible |
| row_drive | output | 7 | Active-high row driver lines |
| ser_data | output | 1 | Serial column bit |
| ser_clk | output | 1 | Shift clock for the external column chain |

## Verification
The hardest case to reach is a `flash_phase` transition that lands after a column event has been taken but before its shift pulse has finished. To produce it, the stimulus raises the column strobe and waits past the synchroniser latency. It then flips `flash_phase` while the shifter is still in `SH_SETUP` or `SH_HIGH`, and does this in both directions. Row code 7 and the disabled-enable case are also awkward to see, because no row line moves. For these, the bench relies on the serial bit, which still follows the stored code, to show what the latch captured.

// File: rtl/rsi_pkg.sv
package rsi_pkg;
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SETUP = 2'd1,
        SH_HIGH  = 2'd2,
        SH_HOLD  = 2'd3
    } shift_state_t;
endpackage

// File: rtl/rsi_strobe_sync.sv
module rsi_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic event_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign event_o = sync_q[STAGES-1] & ~prev_q;

    // R5: an edge event is a single-cycle pulse
    a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o);
endmodule

// File: rtl/rsi_row_latch.sv
module rsi_row_latch #(
    parameter int DATA_W = 8,
    parameter int ROWS   = 7,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] bus,
    output logic [CODE_W-1:0] row_code_o,
    output logic [ROWS-1:0]   row_drive_o
);
    localparam int EN_BIT = CODE_W;

    logic [CODE_W-1:0] code_q;
    logic              off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            off_q  <= 1'b1;
        end else if (load) begin
            code_q <= bus[CODE_W-1:0];
            off_q  <= bus[EN_BIT];
        end
    end

    assign row_code_o = code_q;

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign row_drive_o[i] = !off_q && (code_q == CODE_W'(i));
    end

    // R2: at most one row line is ever driven
    a_r2_onehot_rows: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_drive_o));
    // R3: a load with the enable bit set blanks every row
    a_r3_disable_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bus[EN_BIT]) |=> (row_drive_o == '0));
    // R10: rows move only on a row load
    a_r10_rows_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(row_drive_o));
endmodule

// File: rtl/rsi_shift_fsm.sv
module rsi_shift_fsm
    import rsi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [CODE_W-1:0] row_code,
    input  logic              flash_i,
    output logic              ser_data,
    output logic              ser_clk
);
    localparam int FLASH_BIT = DATA_W - 1;

    shift_state_t state_q, state_d;
    logic         bit_q, bit_d;
    logic         picked, visible;

    assign picked  = byte_i[row_code];
    assign visible = byte_i[FLASH_BIT] | flash_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            bit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        unique case (state_q)
            SH_IDLE: begin
                if (start) begin
                    bit_d   = picked & visible;
                    state_d = SH_SETUP;
                end
            end
            SH_SETUP: state_d = SH_HIGH;
            SH_HIGH:  state_d = SH_HOLD;
            SH_HOLD:  state_d = SH_IDLE;
        endcase
    end

    assign ser_clk  = (state_q == SH_HIGH);
    assign ser_data = bit_q;

    // R5: shift clock high for exactly one cycle
    a_r5_clk_width: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |=> !ser_clk);
    // R5: the host spaces column events so none lands mid-shift
    a_r5_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == SH_IDLE));
    // R9: data unchanged across the rising edge
    a_r9_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));
    // R9: data unchanged in the cycle after the falling edge
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> $stable(ser_data));
endmodule

// File: rtl/row_serial_if.sv
module row_serial_if #(
    parameter int DATA_W      = 8,
    parameter int ROWS        = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              row_stb,
    input  logic              col_stb,
    input  logic              flash_phase,
    output logic [ROWS-1:0]   row_drive,
    output logic              ser_data,
    output logic              ser_clk
);
    localparam int CODE_W = $clog2(DATA_W);

    logic              row_evt, col_evt;
    logic [CODE_W-1:0] code;

    rsi_strobe_sync #(.STAGES(SYNC_STAGES)) u_row_sync (
        .clk(clk), .rst_n(rst_n), .strobe_in(row_stb), .event_o(row_evt));

    rsi_strobe_sync #(.STAGES(SYNC_STAGES)) u_col_sync (
        .clk(clk), .rst_n(rst_n), .strobe_in(col_stb), .event_o(col_evt));

    rsi_row_latch #(.DATA_W(DATA_W), .ROWS(ROWS), .CODE_W(CODE_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .load(row_evt), .bus(bus_data),
        .row_code_o(code), .row_drive_o(row_drive));

    rsi_shift_fsm #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(col_evt), .byte_i(bus_data),
        .row_code(code), .flash_i(flash_phase),
        .ser_data(ser_data), .ser_clk(ser_clk));

    // R10: a row event never starts a shift pulse by itself
    a_r10_row_no_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_evt && !col_evt) |=> !ser_clk);
endmodule

// File: tb/row_serial_if_test.sv
`timescale 1ns/100ps
module row_serial_if_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_data = '0;
    logic       row_stb = 1'b0;
    logic       col_stb = 1'b0;
    logic       flash_phase = 1'b0;
    logic [6:0] row_drive;
    logic       ser_data, ser_clk;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    logic bit_at_rise = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    row_serial_if uut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .row_stb(row_stb),
        .col_stb(col_stb), .flash_phase(flash_phase), .row_drive(row_drive),
        .ser_data(ser_data), .ser_clk(ser_clk));

    // {row byte, column byte, flash, expected rows, expected bit}
    localparam logic [24:0] VEC [13] = '{
        {8'h00, 8'h81, 1'b0, 7'h01, 1'b1},
        {8'h00, 8'h01, 1'b1, 7'h01, 1'b1},
        {8'h00, 8'h01, 1'b0, 7'h01, 1'b0},
        {8'h01, 8'h82, 1'b0, 7'h02, 1'b1},
        {8'h02, 8'hFB, 1'b1, 7'h04, 1'b0},
        {8'h03, 8'h08, 1'b1, 7'h08, 1'b1},
        {8'h04, 8'hEF, 1'b1, 7'h10, 1'b0},
        {8'h05, 8'hA0, 1'b0, 7'h20, 1'b1},
        {8'h06, 8'h40, 1'b1, 7'h40, 1'b1},
        {8'h0E, 8'h40, 1'b1, 7'h00, 1'b1},
        {8'h07, 8'h80, 1'b0, 7'h00, 1'b1},
        {8'h07, 8'h7F, 1'b1, 7'h00, 1'b0},
        {8'hF2, 8'h04, 1'b1, 7'h04, 1'b1}
    };

    always @(posedge ser_clk) begin
        pulses      <= pulses + 1;
        bit_at_rise <= ser_data;
    end

    // R9: the bit seen at the falling edge matches the one at the rising edge
    always @(negedge ser_clk) begin
        if (rst_n) begin
            tests++;
            if (ser_data !== bit_at_rise) begin
                fails++;
                $display("FAIL R9 ser_data moved during pulse: act=%0b exp=%0b",
                         ser_data, bit_at_rise);
            end
        end
    end

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic put_row(input logic [7:0] b);
        @(negedge clk);
        bus_data = b;
        row_stb  = 1'b1;
        repeat (4) @(negedge clk);
        row_stb = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic put_col(input logic [7:0] b, input logic f);
        @(negedge clk);
        bus_data    = b;
        flash_phase = f;
        col_stb     = 1'b1;
        repeat (4) @(negedge clk);
        col_stb = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(row_drive == 7'h00, "R1 rows after reset", row_drive, 0);
        check(ser_clk == 1'b0, "R1 ser_clk after reset", ser_clk, 0);
        check(ser_data == 1'b0, "R1 ser_data after reset", ser_data, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(row_drive == 7'h00, "R1 rows disabled out of reset", row_drive, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        foreach (VEC[i]) begin
            logic [7:0] rb, cb;
            logic       fl, eb;
            logic [6:0] er;
            {rb, cb, fl, er, eb} = VEC[i];
            put_row(rb);
            p0 = pulses;
            put_col(cb, fl);
            check(row_drive == er, "R2/R3/R4 row drive", row_drive, er);
            check(pulses == p0 + 1, "R5 one pulse per column strobe", pulses - p0, 1);
            check(bit_at_rise == eb, "R6/R7/R8 serial bit", bit_at_rise, eb);
        end

        // R10: row strobe gives no pulse; column strobe keeps rows
        p0 = pulses;
        put_row(8'h03);
        check(pulses == p0, "R10 no pulse on row strobe", pulses - p0, 0);
        put_col(8'hFF, 1'b1);
        check(row_drive == 7'h08, "R10 rows kept after column strobe", row_drive, 8);

        // R11: flash changes after the event do not reach the bit
        put_row(8'h00);
        @(negedge clk);
        bus_data = 8'h01; flash_phase = 1'b1; col_stb = 1'b1;
        repeat (4) @(negedge clk);
        flash_phase = 1'b0;
        col_stb = 1'b0;
        repeat (8) @(negedge clk);
        check(bit_at_rise == 1'b1, "R11 late flash fall ignored", bit_at_rise, 1);
        @(negedge clk);
        bus_data = 8'h01; flash_phase = 1'b0; col_stb = 1'b1;
        repeat (4) @(negedge clk);
        flash_phase = 1'b1;
        col_stb = 1'b0;
        repeat (8) @(negedge clk);
        check(bit_at_rise == 1'b0, "R11 late flash rise ignored", bit_at_rise, 0);

        // R3: disabling after an active row blanks it
        put_row(8'h0B);
        check(row_drive == 7'h00, "R3 enable bit set blanks rows", row_drive, 0);

        // R1: reset mid-run returns to idle state
        put_row(8'h02);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(row_drive == 7'h00, "R1 rows after second reset", row_drive, 0);
        check(ser_data == 1'b0, "R1 data after second reset", ser_data, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule